// File: doc/BRIEF.md
# Loadable Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width (four bits by default). On each rising clock edge it can hold its value, take a new value from a parallel data input, or move one step up or down. A direction input chooses whether a step adds one or subtracts one. The count wraps modulo two to the power of the width in both directions.

Every bit is a toggle stage. Bit 0 toggles on every enabled step. A higher bit toggles only when the step reaches it through an unbroken run of lower bits. In up mode those lower bits must all be one; in down mode they must all be zero.

A cascade output goes high when an enabled step is about to wrap the counter. Feeding that output into the step enable of the next, more significant stage chains several counters into one wider counter on the same clock.

Top module: `updn_load_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge, the count becomes 0 at that edge. Reset overrides load and step.
- R2: When `load_i` is 1 (and `rst_n` is high), the count takes `par_d_i` at the next edge. This happens whatever the values of `step_en_i` and `dir_dn_i`.
- R3: When `load_i` is 0 and `step_en_i` is 0, the count keeps its value, whatever `par_d_i` and `dir_dn_i` are.
- R4: When `load_i` is 0, `step_en_i` is 1 and `dir_dn_i` is 0 (up), the count becomes (count + 1) mod 2^WIDTH. The all-ones value wraps to 0.
- R5: When `load_i` is 0, `step_en_i` is 1 and `dir_dn_i` is 1 (down), the count becomes (count - 1) mod 2^WIDTH. Zero wraps to all-ones.
- R6: On every enabled step (load low, step enable high), bit 0 of the count inverts.
- R7: `cascade_o` is 1 in the same cycle when `step_en_i` is 1, `load_i` is 0, and the count is at its terminal value for the direction. The terminal value is all ones in up mode and all zeros in down mode.
- R8: `cascade_o` is 0 whenever `step_en_i` is 0, `load_i` is 1, or the count is not at the terminal value for the current direction.
- R9: Two stages of width W form a single counter of width 2W when they share the clock, reset, load and direction, and the lower stage's `cascade_o` drives the upper stage's `step_en_i`. The pair then counts, wraps and loads as one 2W-bit counter, and the upper `cascade_o` acts as its cascade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by every flip-flop |
| rst_n | input | 1 | Synchronous reset, active low, clears the count |
| load_i | input | 1 | Parallel load request; takes priority over stepping |
| step_en_i | input | 1 | Step enable; also the cascade input from a lower stage |
| dir_dn_i | input | 1 | Direction: 0 counts up, 1 counts down |
| par_d_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Current count |
| cascade_o | output | 1 | High when an enabled step wraps this stage |

## Verification
The bench builds the counter at its default width of 4. With 16 states, wrap-around in both directions, reset, loads during stepping and long random runs are all reached within a few hundred cycles. It also builds two 3-bit stages chained through the cascade output into one 6-bit counter. That arrangement exercises the cascade output as a real step enable, including steps that ripple a wrap into the upper stage and borrows across the stage boundary in down mode.

// File: rtl/updn_cnt_pkg.sv
// Package: shared types of the loadable up/down counter.
// Assumes: nothing; it holds only type definitions.
package updn_cnt_pkg;

    // Count direction as decoded from the direction pin.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Operation applied to the state at the next clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } op_e;

endpackage

// File: rtl/updn_toggle_chain.sv
// Module: toggle-condition chain.
// For each bit it produces a toggle flag. Bit 0 toggles whenever stepping
// is enabled. Bit i toggles when the enable reaches it through bits below
// that are all 1 (up) or all 0 (down). This is serial gating: the chain
// depth grows linearly with WIDTH.
// Assumes: WIDTH >= 1; purely combinational.
module updn_toggle_chain
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             step_en,
    input  dir_e             dir,
    input  logic [WIDTH-1:0] cur_q,
    output logic [WIDTH-1:0] tgl
);

    logic [WIDTH-1:0] reach;

    // Bit 0 sees the enable directly.
    assign reach[0] = step_en;

    // Each higher bit receives the enable only through a matching lower bit.
    generate
        for (genvar gi = 1; gi < WIDTH; gi++) begin : g_link
            assign reach[gi] = reach[gi-1] &
                               ((dir == DIR_DOWN) ? ~cur_q[gi-1] : cur_q[gi-1]);
        end
    endgenerate

    // The toggle flags are the propagated enables.
    assign tgl = reach;

endmodule

// File: rtl/updn_terminal_detect.sv
// Module: terminal-count detector.
// It raises the cascade output for a step that will wrap the counter:
// all ones going up, all zeros going down. The output is gated by the step
// enable and by the absence of a load, so a chained upper stage advances
// only on a real wrap.
// Assumes: purely combinational; the caller registers nothing here.
module updn_terminal_detect
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             step_en,
    input  logic             load,
    input  dir_e             dir,
    input  logic [WIDTH-1:0] cur_q,
    output logic             cascade
);

    logic at_top;
    logic at_bottom;
    logic at_term;

    // Reduction compares against the two wrap points.
    always_comb begin
        at_top    = &cur_q;
        at_bottom = ~|cur_q;
        at_term   = (dir == DIR_DOWN) ? at_bottom : at_top;
        cascade   = step_en & ~load & at_term;
    end

endmodule

// File: rtl/updn_state_reg.sv
// Module: count state register.
// It holds the count and applies the decoded operation at each edge:
// hold, load the parallel word, or invert the bits flagged by the toggle
// chain. Reset is synchronous, active low, and clears the count.
// Assumes: op is stable before the edge; tgl has the same width as the state.
module updn_state_reg
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] par_d,
    input  logic [WIDTH-1:0] tgl,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_nxt;

    // Select the next state from the operation.
    always_comb begin
        unique case (op)
            OP_LOAD: q_nxt = par_d;
            OP_STEP: q_nxt = q ^ tgl;
            default: q_nxt = q;
        endcase
    end

    // Register the state with a synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/updn_load_counter.sv
// Module: loadable up/down binary counter (top).
// It decodes load and step into an operation. Load wins over stepping.
// A toggle chain computes which bits move, and a terminal detector drives
// the cascade output for chaining stages.
// Assumes: one clock for all stages; par_d_i is synchronous to clk.
module updn_load_counter
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_en_i,
    input  logic             dir_dn_i,
    input  logic [WIDTH-1:0] par_d_i,
    output logic [WIDTH-1:0] count_o,
    output logic             cascade_o
);

    dir_e             dir;
    op_e              op;
    logic [WIDTH-1:0] tgl;
    logic [WIDTH-1:0] q;

    // Decode direction and operation; load has priority over stepping.
    always_comb begin
        dir = dir_e'(dir_dn_i);
        if (load_i) begin
            op = OP_LOAD;
        end else if (step_en_i) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

    updn_toggle_chain #(.WIDTH(WIDTH)) u_chain (
        .step_en (step_en_i),
        .dir     (dir),
        .cur_q   (q),
        .tgl     (tgl)
    );

    updn_terminal_detect #(.WIDTH(WIDTH)) u_term (
        .step_en (step_en_i),
        .load    (load_i),
        .dir     (dir),
        .cur_q   (q),
        .cascade (cascade_o)
    );

    updn_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .par_d (par_d_i),
        .tgl   (tgl),
        .q     (q)
    );

    assign count_o = q;

endmodule

// File: rtl/updn_load_counter_chk.sv
// Module: assertion checker for the loadable up/down counter, bound to the top.
// Assumes: it observes the top's ports only.
module updn_load_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             step_en_i,
    input logic             dir_dn_i,
    input logic [WIDTH-1:0] par_d_i,
    input logic [WIDTH-1:0] count_o,
    input logic             cascade_o
);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(par_d_i)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_en_i) |=> $stable(count_o));

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_en_i && !dir_dn_i) |=>
            (count_o == WIDTH'($past(count_o) + 1'b1)));

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_en_i && dir_dn_i) |=>
            (count_o == WIDTH'($past(count_o) - 1'b1)));

    assert_lsb_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_en_i) |=> (count_o[0] != $past(count_o[0])));

    assert_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_en_i && !dir_dn_i && (&count_o)) |-> cascade_o);

    assert_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_en_i && dir_dn_i && !(|count_o)) |-> cascade_o);

    assert_quiet_cascade_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_i || load_i) |-> !cascade_o);

endmodule

bind updn_load_counter updn_load_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .step_en_i (step_en_i),
    .dir_dn_i  (dir_dn_i),
    .par_d_i   (par_d_i),
    .count_o   (count_o),
    .cascade_o (cascade_o)
);

// File: tb/updn_load_counter_bench.sv
// Bench: behavioural reference model compared on every clock for a 4-bit
// counter and for two chained 3-bit stages acting as one 6-bit counter.
module updn_load_counter_bench;

    localparam int W   = 4;
    localparam int PW  = 3;
    localparam int M4  = 16;
    localparam int M6  = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          load  = 1'b0;
    logic          en    = 1'b0;
    logic          dn    = 1'b0;
    logic [W-1:0]  d4    = '0;
    logic [2*PW-1:0] d6  = '0;

    logic [W-1:0]  cnt4;
    logic          cas4;
    logic [PW-1:0] lo_q, hi_q;
    logic          lo_cas, hi_cas;

    updn_load_counter #(.WIDTH(W)) u_updn_load_counter (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_en_i(en),
        .dir_dn_i(dn), .par_d_i(d4), .count_o(cnt4), .cascade_o(cas4));

    updn_load_counter #(.WIDTH(PW)) u_lo (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_en_i(en),
        .dir_dn_i(dn), .par_d_i(d6[PW-1:0]), .count_o(lo_q), .cascade_o(lo_cas));

    updn_load_counter #(.WIDTH(PW)) u_hi (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_en_i(lo_cas),
        .dir_dn_i(dn), .par_d_i(d6[2*PW-1:PW]), .count_o(hi_q), .cascade_o(hi_cas));

    int n_vec = 0;
    int n_bad = 0;
    int m4 = 0;
    int m6 = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_next(int m, int md, bit r, bit l, bit e, bit down, int dv);
        if (!r)   return 0;
        if (l)    return dv % md;
        if (!e)   return m;
        if (down) return (m + md - 1) % md;
        return (m + 1) % md;
    endfunction

    function automatic int ref_term(int m, int md, bit down);
        return down ? int'(m == 0) : int'(m == md - 1);
    endfunction

    // One cycle: drive at the falling edge, check the cascade, then check the count after the rising edge.
    task automatic step(input bit r, input bit l, input bit e, input bit down, input int dv);
        string t;
        int    old4;
        rst_n = r; load = l; en = e; dn = down;
        d4 = W'(dv % M4);
        d6 = (2*PW)'(dv % M6);
        #1;
        chk((e && !l && ref_term(m4, M4, down) == 1) ? "R7" : "R8",
            int'(cas4), (e && !l) ? ref_term(m4, M4, down) : 0);
        chk("R9", int'(hi_cas), (e && !l) ? ref_term(m6, M6, down) : 0);
        old4 = m4;
        @(posedge clk);
        m4 = ref_next(m4, M4, r, l, e, down, dv);
        m6 = ref_next(m6, M6, r, l, e, down, dv);
        @(negedge clk);
        if (!r)        t = "R1";
        else if (l)    t = "R2";
        else if (!e)   t = "R3";
        else if (down) t = "R5";
        else           t = "R4";
        chk(t, int'(cnt4), m4);
        chk("R9", int'({hi_q, lo_q}), m6);
        if (r && !l && e) chk("R6", int'(cnt4[0]), (old4 % 2 == 0) ? 1 : 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        m4 = 0; m6 = 0;
        chk("R1", int'(cnt4), 0);
        chk("R9", int'({hi_q, lo_q}), 0);
        step(0, 1, 1, 0, 9);          // reset beats load (R1)
        step(1, 1, 0, 0, 9);          // load with stepping off (R2)
        step(1, 1, 1, 1, 38);         // load while stepping down (R2)
        for (int k = 0; k < 3; k++) step(1, 0, 0, k % 2, 5 + k);   // hold (R3)
        for (int k = 0; k < 20; k++) step(1, 0, 1, 0, k);          // up, wraps (R4)
        step(1, 1, 0, 0, 61);
        for (int k = 0; k < 6; k++) step(1, 0, 1, 0, 0);           // both widths wrap up
        step(1, 1, 0, 1, 2);
        for (int k = 0; k < 5; k++) step(1, 0, 1, 1, 0);           // both widths wrap down (R5)
        for (int k = 0; k < 40; k++) step(1, 0, 1, 1, k);
        for (int k = 0; k < 400; k++)
            step(($urandom_range(29) != 0), ($urandom_range(7) == 0),
                 ($urandom_range(3) != 0), 1'($urandom_range(1)),
                 int'($urandom_range(63)));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (R1..R9 not completed) actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule